// File: doc/BRIEF.md
# Serial-Parallel Shift-Accumulate Multiplier

This block forms the unsigned product of two 8-bit operands using a single adder. The multiplicand is held as a parallel word. The multiplier is consumed one bit per clock, least significant bit first. On each step the adder adds either the multiplicand or zero into the upper part of a 17-bit accumulator. The whole accumulator then shifts right by one place. After eight steps the accumulator holds the full product. Area is kept as small as possible, and the price is one clock for each multiplier bit.

The caller pulses `start` with both operands present. The block loads them, clears the accumulator and runs for exactly eight cycles. It then raises `done` for one cycle. The product stays on the output until the next accepted start. While a multiply is running, a start pulse is ignored.

Top module: `smul_serpar`

## Requirements
- R1: After reset, `product` is 0 and `done` is 0.
- R2: When idle, a `start` pulse is accepted at a clock edge. It captures `a_in` and `b_in` and clears the accumulator, so `product` reads 0 in the cycle after acceptance.
- R3: `done` rises in the cycle after the 8th clock edge that follows the accepting edge. It is low for the seven cycles before that, and it is never high while a multiply is running.
- R4: `done` is high for exactly one cycle per product.
- R5: When `done` is high, `product[15:0]` equals the unsigned value `a_in * b_in` of the accepted operands.
- R6: When `done` is high, `product[16]` is 0.
- R7: A `start` pulse that arrives while a multiply is running has no effect: the running product, its operands and its timing are unchanged.
- R8: While idle, `product` keeps its value until the next accepted start.
- R9: The multiplier bits are taken LSB first, one per clock. After the first step, `product` equals `(b_in[0] ? a_in : 0) << 7`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply (ignored while busy) |
| a_in | input | 8 | Parallel multiplicand |
| b_in | input | 8 | Multiplier, consumed serially LSB first |
| product | output | 17 | Accumulator contents; holds the product when done |
| done | output | 1 | One-cycle completion flag |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a running multiply. The pulse carries different operands, and it must be shown to corrupt neither the result nor the completion cycle. The stimulus counts clock edges from acceptance and raises `start` with decoy operands after the third step. It then lowers `start` one step later and expects the original product on the eighth step. A sweep over every multiplicand against a spread of multiplier patterns, including 0 and 255, covers carries out of the adder at every shift position.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    SM_IDLE = 1'b0,
    SM_RUN  = 1'b1
  } smul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step_en,
  output logic last_step,
  output logic busy,
  output logic done
);
  import smul_pkg::*;
  localparam int CNT_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N - 1);

  smul_state_e state_q;
  logic [CNT_W-1:0] cnt_q;
  logic done_q;

  assign busy      = (state_q == SM_RUN);
  assign accept    = start && !busy;
  assign step_en   = busy;
  assign last_step = busy && (cnt_q == LAST_CNT);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SM_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_step;
      if (accept) begin
        state_q <= SM_RUN;
        cnt_q   <= '0;
      end else if (last_step) begin
        state_q <= SM_IDLE;
        cnt_q   <= '0;
      end else if (busy) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step_en,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic [2*N:0]   acc_o
);
  localparam int ACC_W = 2 * N + 1;

  logic [N-1:0]     mcand_q;
  logic [N-1:0]     mplier_q;
  logic [ACC_W-1:0] acc_q;

  // One shift-accumulate step: add the gated multiplicand to the upper
  // N+1 bits, then shift the whole register right by one place.
  function automatic logic [ACC_W-1:0] acc_step(
    input logic [ACC_W-1:0] acc,
    input logic [N-1:0]     mc,
    input logic             bit_in
  );
    logic [N:0] upper;
    upper = acc[2*N:N] + {1'b0, (bit_in ? mc : {N{1'b0}})};
    return {1'b0, upper, acc[N-1:1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load) begin
      mcand_q  <= a_in;
      mplier_q <= b_in;
      acc_q    <= '0;
    end else if (step_en) begin
      acc_q    <= acc_step(acc_q, mcand_q, mplier_q[0]);
      mplier_q <= mplier_q >> 1;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/smul_serpar.sv
module smul_serpar #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic [2*N:0]   product,
  output logic           done
);
  logic accept;
  logic step_en;
  logic last_step;
  logic busy;

  smul_ctrl #(.N(N)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .accept    (accept),
    .step_en   (step_en),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  smul_datapath #(.N(N)) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .step_en (step_en),
    .a_in    (a_in),
    .b_in    (b_in),
    .acc_o   (product)
  );
endmodule

// File: rtl/smul_serpar_chk.sv
module smul_serpar_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         accept,
  input logic         busy,
  input logic         last_step,
  input logic         done,
  input logic [2*N:0] product
);
  assert_accept_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && product == '0));

  assert_last_gives_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done);

  assert_done_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_top_bit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !product[2*N]);

  assert_run_continues_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

bind smul_serpar smul_serpar_chk #(.N(N)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .accept    (accept),
  .busy      (busy),
  .last_step (last_step),
  .done      (done),
  .product   (product)
);

// File: tb/test_smul_serpar.sv
module test_smul_serpar;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   a_in = '0;
  logic [N-1:0]   b_in = '0;
  logic [2*N:0]   product;
  logic           done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  smul_serpar #(.N(N)) i_smul_serpar (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .a_in    (a_in),
    .b_in    (b_in),
    .product (product),
    .done    (done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run one multiply; if interfere is set, pulse start with decoy operands mid-run.
  task automatic run_mult(input logic [N-1:0] a, input logic [N-1:0] b, input bit interfere);
    longint exp_p;
    exp_p = longint'(a) * longint'(b);
    @(negedge clk);
    start = 1'b1; a_in = a; b_in = b;
    @(negedge clk);
    start = 1'b0; a_in = ~a; b_in = ~b;
    check(product == '0, "R2", product, 0);
    for (int i = 1; i <= N; i++) begin
      @(negedge clk);
      if (i == 1)
        check(product == ((b[0] ? longint'(a) : 0) << (N - 1)), "R9", product, (b[0] ? longint'(a) : 0) << (N - 1));
      if (interfere && i == 3) begin
        start = 1'b1; a_in = 8'd1; b_in = 8'd1;
      end
      if (interfere && i == 4) begin
        start = 1'b0;
      end
      if (i == N - 1) check(done == 1'b0, "R3", done, 0);
      if (i == N) begin
        check(done == 1'b1, "R3", done, 1);
        check(product[2*N-1:0] == exp_p[2*N-1:0], interfere ? "R7" : "R5", product, exp_p);
        check(product[2*N] == 1'b0, "R6", product[2*N], 0);
      end
    end
    @(negedge clk);
    check(done == 1'b0, "R4", done, 0);
  endtask

  initial begin
    logic [2*N:0] held;
    @(negedge clk);
    check(product == '0, "R1", product, 0);
    check(done == 1'b0, "R1", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Corner cases
    run_mult(8'd0, 8'd0, 1'b0);
    run_mult(8'd255, 8'd255, 1'b0);
    run_mult(8'd255, 8'd1, 1'b0);
    run_mult(8'd1, 8'd128, 1'b0);

    // R7: start during a running multiply is ignored
    run_mult(8'd200, 8'd150, 1'b1);
    run_mult(8'd77, 8'd0, 1'b1);

    // R8: product holds while idle
    run_mult(8'd173, 8'd91, 1'b0);
    held = product;
    for (int k = 0; k < 5; k++) @(negedge clk);
    check(product == held, "R8", product, held);
    check(done == 1'b0, "R8", done, 0);

    // Sweep: every multiplicand against a spread of multiplier patterns (R5)
    for (int ai = 0; ai < 256; ai++) begin
      for (int j = 0; j < 32; j++) begin
        logic [N-1:0] bv;
        if (j == 0) bv = 8'd0;
        else if (j == 1) bv = 8'd255;
        else bv = 8'((j * 37 + j / 3 + 11) & 255);
        run_mult(8'(ai), bv, 1'b0);
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule